// File: doc/BRIEF.md
# Hashed Page Table Walker

The walker turns a 32-bit effective address into a physical address by searching a hashed page table that sits in ordinary memory. Sixteen segment registers and one table register are loaded through a small write port. A request brings an effective address and a flag that marks it as an instruction fetch or a data access. Two enable inputs say whether translation is on for each of those access types.

When translation is off, or the chosen segment is marked direct, or an outside block-translation unit reports a hit, the answer comes back on the next cycle and no memory is read. In all other cases the walker hashes the segment's virtual segment ID with the page number. It reads page-table entries one 32-bit word at a time over a valid/ready port, first from the primary group and then from the secondary group. It returns either the physical address or a fault. One request is handled at a time.

Top module: `hpt_walker`

## Requirements
- R1: After reset req_ready_o is 1 and rsp_valid_o and mem_valid_o are 0.
- R2: An accepted request (req_valid_i and req_ready_o) whose access type has translation off (itx_en_i for req_inst_i=1, dtx_en_i for req_inst_i=0) gives rsp_valid_o on the next cycle with rsp_pa_o equal to the address, rsp_fault_o 0, and no memory read.
- R3: The segment register is picked by address bits [31:28] and its bits [23:0] are the VSID. A write with cfg_seg_we_i stores cfg_wdata_i into segment cfg_seg_idx_i. A write with cfg_tbl_we_i stores it into the table register.
- R4: If bit 31 of the picked segment is 1, the response comes on the next cycle with address {segment[3:0], ea[27:0]} and no memory read.
- R5: If translation is on, the segment is not direct and bat_hit_i is 1 at acceptance, the response comes on the next cycle with bat_pa_i and no memory read.
- R6: Group address = {tbl[31:16], 16'h0} + ((hash & {tbl[8:0], 10'h3FF}) << 6).
- R7: Primary hash = VSID[18:0] ^ ea[27:12] (19 bits). Secondary hash = primary ^ 19'h7FFFF.
- R8: Entry i (0..7) of a group has its high word at group+8*i and its low word at group+8*i+4. High words are read in order 0..7. A low word is read only after its high word matches.
- R9: A high word matches when bits [30:7] equal the VSID, bit 6 equals the hash select (0 primary, 1 secondary), and bits [5:0] equal ea[27:22]. Bit 31 is not tested.
- R10: On a match the response is {low[31:12], ea[11:0]} with rsp_fault_o 0.
- R11: The secondary group is searched only after all eight primary entries miss. If it also misses, the response has rsp_fault_o 1 and rsp_pa_o 0, after exactly 16 reads.
- R12: req_ready_o is 0 while a walk is in flight. At most one read is outstanding. A read that is not accepted keeps mem_valid_o and mem_addr_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_seg_we_i | input | 1 | Write enable for a segment register |
| cfg_seg_idx_i | input | 4 | Segment register index for a write |
| cfg_tbl_we_i | input | 1 | Write enable for the table register |
| cfg_wdata_i | input | 32 | Write data for the configuration registers |
| itx_en_i | input | 1 | Translation enabled for instruction fetches |
| dtx_en_i | input | 1 | Translation enabled for data accesses |
| req_valid_i | input | 1 | Translation request valid |
| req_ready_o | output | 1 | Walker idle and able to accept a request |
| req_ea_i | input | 32 | Effective address |
| req_inst_i | input | 1 | 1 = instruction fetch, 0 = data access |
| bat_hit_i | input | 1 | Block-translation hit; takes the place of the walk |
| bat_pa_i | input | 32 | Physical address from block translation |
| mem_valid_o | output | 1 | Word read request valid |
| mem_ready_i | input | 1 | Memory accepts the read request |
| mem_addr_o | output | 32 | Byte address of the word read |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read data |
| rsp_valid_o | output | 1 | Response valid, one-cycle pulse |
| rsp_pa_o | output | 32 | Physical address; 0 when a fault is reported |
| rsp_fault_o | output | 1 | No matching entry in either group |

## Verification
The assertions assume that memory returns read data at least one cycle after it accepts a read. They also assume that mem_rvalid_i rises only for a read the walker has in flight, and that no configuration write happens during a walk. The bench's memory model answers exactly one cycle after accepting a read and stalls acceptance in a fixed repeating pattern. The bench writes configuration only between requests, while the walker is idle. Expected addresses, fault flags and read counts come from the hash arithmetic of the requirements. Entries are placed in every slot of both groups for each segment, together with decoy entries that differ in a single matched field.

// File: rtl/hpt_pkg.sv
package hpt_pkg;
  localparam int unsigned XLEN          = 32;
  localparam int unsigned NUM_SEG       = 16;
  localparam int unsigned SEG_SEL_W     = $clog2(NUM_SEG);
  localparam int unsigned VSID_W        = 24;
  localparam int unsigned HASH_W        = 19;
  localparam int unsigned TBL_SIZE_W    = 9;
  localparam int unsigned GROUP_ENTRIES = 8;
  localparam int unsigned ENTRY_IDX_W   = $clog2(GROUP_ENTRIES);
  localparam int unsigned PTE_SHIFT     = 3;
  localparam int unsigned GROUP_SHIFT   = ENTRY_IDX_W + PTE_SHIFT;
  localparam int unsigned PAGE_SHIFT    = 12;
  localparam int unsigned API_W         = 6;
  localparam int unsigned MAX_READS     = 2 * GROUP_ENTRIES + 1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HI_REQ,
    ST_HI_WAIT,
    ST_LO_REQ,
    ST_LO_WAIT
  } walk_state_e;
endpackage

// File: rtl/hpt_regs.sv
module hpt_regs
  import hpt_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 seg_we_i,
  input  logic [SEG_SEL_W-1:0] seg_idx_i,
  input  logic                 tbl_we_i,
  input  logic [XLEN-1:0]      wdata_i,
  input  logic [SEG_SEL_W-1:0] rd_idx_i,
  output logic [XLEN-1:0]      seg_o,
  output logic [XLEN-1:0]      tbl_o
);
  logic [XLEN-1:0] seg_q [NUM_SEG];
  logic [XLEN-1:0] tbl_q;

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                          seg_q[g] <= '0;
      else if (seg_we_i && seg_idx_i == SEG_SEL_W'(g)) seg_q[g] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       tbl_q <= '0;
    else if (tbl_we_i) tbl_q <= wdata_i;
  end

  assign seg_o = seg_q[rd_idx_i];
  assign tbl_o = tbl_q;

  a_r3_seg_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seg_we_i |=> seg_q[$past(seg_idx_i)] == $past(wdata_i));
  a_r3_tbl_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tbl_we_i |=> tbl_o == $past(wdata_i));
endmodule

// File: rtl/hpt_hash.sv
module hpt_hash
  import hpt_pkg::*;
(
  input  logic [VSID_W-1:0]      vsid_i,
  input  logic [XLEN-1:0]        ea_i,
  input  logic                   sec_i,
  input  logic [XLEN-1:0]        tbl_i,
  input  logic [ENTRY_IDX_W-1:0] entry_i,
  input  logic                   lo_word_i,
  output logic [XLEN-1:0]        addr_o
);
  localparam int unsigned PN_W = 28 - PAGE_SHIFT;

  logic [HASH_W-1:0] hash_p, hash_s, mask;
  logic [XLEN-1:0]   base, grp_off, ent_off;

  assign hash_p  = vsid_i[HASH_W-1:0] ^ HASH_W'(ea_i[PAGE_SHIFT +: PN_W]);
  assign hash_s  = sec_i ? ~hash_p : hash_p;
  assign mask    = {tbl_i[TBL_SIZE_W-1:0], {(HASH_W-TBL_SIZE_W){1'b1}}};
  assign base    = {tbl_i[XLEN-1:16], 16'h0};
  assign grp_off = XLEN'(hash_s & mask) << GROUP_SHIFT;
  assign ent_off = (XLEN'(entry_i) << PTE_SHIFT) | (lo_word_i ? XLEN'(4) : XLEN'(0));
  assign addr_o  = base + grp_off + ent_off;
endmodule

// File: rtl/hpt_match.sv
module hpt_match
  import hpt_pkg::*;
(
  input  logic [XLEN-1:0]   hi_i,
  input  logic [VSID_W-1:0] vsid_i,
  input  logic              sec_i,
  input  logic [XLEN-1:0]   ea_i,
  output logic              hit_o
);
  logic vsid_eq, sel_eq, api_eq;

  assign vsid_eq = hi_i[API_W+1 +: VSID_W] == vsid_i;
  assign sel_eq  = hi_i[API_W] == sec_i;
  assign api_eq  = hi_i[API_W-1:0] == ea_i[27 -: API_W];
  assign hit_o   = vsid_eq && sel_eq && api_eq;
endmodule

// File: rtl/hpt_walker.sv
module hpt_walker
  import hpt_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cfg_seg_we_i,
  input  logic [3:0]  cfg_seg_idx_i,
  input  logic        cfg_tbl_we_i,
  input  logic [31:0] cfg_wdata_i,
  input  logic        itx_en_i,
  input  logic        dtx_en_i,
  input  logic        req_valid_i,
  output logic        req_ready_o,
  input  logic [31:0] req_ea_i,
  input  logic        req_inst_i,
  input  logic        bat_hit_i,
  input  logic [31:0] bat_pa_i,
  output logic        mem_valid_o,
  input  logic        mem_ready_i,
  output logic [31:0] mem_addr_o,
  input  logic        mem_rvalid_i,
  input  logic [31:0] mem_rdata_i,
  output logic        rsp_valid_o,
  output logic [31:0] rsp_pa_o,
  output logic        rsp_fault_o
);
  localparam int unsigned CNT_W = $clog2(MAX_READS + 1);

  walk_state_e            st_q;
  logic [XLEN-1:0]        ea_q;
  logic [VSID_W-1:0]      vsid_q;
  logic                   sec_q;
  logic [ENTRY_IDX_W-1:0] idx_q;
  logic                   rsp_valid_q, rsp_fault_q;
  logic [XLEN-1:0]        rsp_pa_q;
  logic [CNT_W-1:0]       rd_cnt_q;

  logic [XLEN-1:0] seg_rd, tbl;
  logic            tx_on, hi_hit, lo_phase, accept;

  hpt_regs u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .seg_we_i (cfg_seg_we_i),
    .seg_idx_i(cfg_seg_idx_i),
    .tbl_we_i (cfg_tbl_we_i),
    .wdata_i  (cfg_wdata_i),
    .rd_idx_i (req_ea_i[31:28]),
    .seg_o    (seg_rd),
    .tbl_o    (tbl)
  );

  assign lo_phase = (st_q == ST_LO_REQ) || (st_q == ST_LO_WAIT);

  hpt_hash u_hash (
    .vsid_i   (vsid_q),
    .ea_i     (ea_q),
    .sec_i    (sec_q),
    .tbl_i    (tbl),
    .entry_i  (idx_q),
    .lo_word_i(lo_phase),
    .addr_o   (mem_addr_o)
  );

  hpt_match u_match (
    .hi_i  (mem_rdata_i),
    .vsid_i(vsid_q),
    .sec_i (sec_q),
    .ea_i  (ea_q),
    .hit_o (hi_hit)
  );

  assign tx_on       = req_inst_i ? itx_en_i : dtx_en_i;
  assign req_ready_o = (st_q == ST_IDLE);
  assign accept      = req_valid_i && req_ready_o;
  assign mem_valid_o = (st_q == ST_HI_REQ) || (st_q == ST_LO_REQ);
  assign rsp_valid_o = rsp_valid_q;
  assign rsp_pa_o    = rsp_pa_q;
  assign rsp_fault_o = rsp_fault_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      ea_q        <= '0;
      vsid_q      <= '0;
      sec_q       <= 1'b0;
      idx_q       <= '0;
      rsp_valid_q <= 1'b0;
      rsp_fault_q <= 1'b0;
      rsp_pa_q    <= '0;
      rd_cnt_q    <= '0;
    end else begin
      rsp_valid_q <= 1'b0;
      if (mem_valid_o && mem_ready_i) rd_cnt_q <= rd_cnt_q + 1'b1;
      unique case (st_q)
        ST_IDLE: if (accept) begin
          ea_q     <= req_ea_i;
          vsid_q   <= seg_rd[VSID_W-1:0];
          sec_q    <= 1'b0;
          idx_q    <= '0;
          rd_cnt_q <= '0;
          if (!tx_on) begin
            rsp_valid_q <= 1'b1; rsp_fault_q <= 1'b0; rsp_pa_q <= req_ea_i;
          end else if (seg_rd[31]) begin
            rsp_valid_q <= 1'b1; rsp_fault_q <= 1'b0;
            rsp_pa_q    <= {seg_rd[3:0], req_ea_i[27:0]};
          end else if (bat_hit_i) begin
            rsp_valid_q <= 1'b1; rsp_fault_q <= 1'b0; rsp_pa_q <= bat_pa_i;
          end else begin
            st_q <= ST_HI_REQ;
          end
        end
        ST_HI_REQ: if (mem_ready_i) st_q <= ST_HI_WAIT;
        ST_HI_WAIT: if (mem_rvalid_i) begin
          if (hi_hit) begin
            st_q <= ST_LO_REQ;
          end else if (idx_q == ENTRY_IDX_W'(GROUP_ENTRIES - 1)) begin
            idx_q <= '0;
            if (sec_q) begin
              st_q        <= ST_IDLE;
              rsp_valid_q <= 1'b1;
              rsp_fault_q <= 1'b1;
              rsp_pa_q    <= '0;
            end else begin
              sec_q <= 1'b1;
              st_q  <= ST_HI_REQ;
            end
          end else begin
            idx_q <= idx_q + 1'b1;
            st_q  <= ST_HI_REQ;
          end
        end
        ST_LO_REQ: if (mem_ready_i) st_q <= ST_LO_WAIT;
        ST_LO_WAIT: if (mem_rvalid_i) begin
          st_q        <= ST_IDLE;
          rsp_valid_q <= 1'b1;
          rsp_fault_q <= 1'b0;
          rsp_pa_q    <= {mem_rdata_i[XLEN-1:PAGE_SHIFT], ea_q[PAGE_SHIFT-1:0]};
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  a_r2_passthru: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && !tx_on |=> rsp_valid_o && !rsp_fault_o && rsp_pa_o == $past(req_ea_i));
  a_r8_hi_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o && !lo_phase |-> mem_addr_o[2:0] == 3'd0);
  a_r8_lo_offset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o && lo_phase |-> mem_addr_o[2:0] == 3'd4);
  a_r11_fault_pa_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_fault_o |-> rsp_pa_o == '0);
  a_r11_read_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_cnt_q <= CNT_W'(MAX_READS));
  a_r12_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o && !mem_ready_i |=> mem_valid_o && $stable(mem_addr_o));
  a_r12_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o |-> !req_ready_o);
endmodule

// File: tb/tb_hpt_walker.sv
module tb_hpt_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_seg_we = 1'b0, cfg_tbl_we = 1'b0;
  logic [3:0]  cfg_seg_idx = '0;
  logic [31:0] cfg_wdata = '0;
  logic        itx_en = 1'b1, dtx_en = 1'b1;
  logic        req_valid = 1'b0, req_inst = 1'b0;
  logic        req_ready;
  logic [31:0] req_ea = '0;
  logic        bat_hit = 1'b0;
  logic [31:0] bat_pa = '0;
  logic        mem_valid, mem_ready = 1'b0, mem_rvalid = 1'b0;
  logic [31:0] mem_addr, mem_rdata = '0;
  logic        rsp_valid, rsp_fault;
  logic [31:0] rsp_pa;

  int checks = 0, fails = 0, nreads = 0, stall_ctr = 0;
  bit done = 0;
  logic [31:0] mem [logic [31:0]];
  logic [31:0] seg_m [16];
  logic [31:0] tbl_m = '0;

  always #2.5 clk = ~clk;

  hpt_walker dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_seg_we_i(cfg_seg_we), .cfg_seg_idx_i(cfg_seg_idx),
    .cfg_tbl_we_i(cfg_tbl_we), .cfg_wdata_i(cfg_wdata),
    .itx_en_i(itx_en), .dtx_en_i(dtx_en),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_ea_i(req_ea), .req_inst_i(req_inst),
    .bat_hit_i(bat_hit), .bat_pa_i(bat_pa),
    .mem_valid_o(mem_valid), .mem_ready_i(mem_ready), .mem_addr_o(mem_addr),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
    .rsp_valid_o(rsp_valid), .rsp_pa_o(rsp_pa), .rsp_fault_o(rsp_fault)
  );

  function automatic logic [31:0] rd_word(logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'hFFFF_FFFF;
  endfunction

  // memory model: one-cycle read latency, acceptance stalls every third cycle
  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (rst_n && mem_valid && mem_ready) begin
      mem_rvalid <= 1'b1;
      mem_rdata  <= rd_word(mem_addr);
      nreads     <= nreads + 1;
    end
    stall_ctr <= stall_ctr + 1;
    mem_ready <= (stall_ctr % 3) != 0;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] grp_addr(logic [23:0] vsid, logic [31:0] ea, bit sec);
    logic [18:0] h;
    h = vsid[18:0] ^ {3'b0, ea[27:12]};
    if (sec) h = h ^ 19'h7FFFF;
    return {tbl_m[31:16], 16'h0} + ({13'b0, h & {tbl_m[8:0], 10'h3FF}} << 6);
  endfunction

  // reference walk built from R6..R11
  task automatic ref_walk(logic [31:0] ea, output logic [31:0] pa, output bit flt, output int rds);
    logic [23:0] vsid;
    logic [31:0] hi, ga;
    vsid = seg_m[ea[31:28]][23:0];
    rds = 0;
    for (int s = 0; s < 2; s++) begin
      ga = grp_addr(vsid, ea, bit'(s));
      for (int i = 0; i < 8; i++) begin
        hi = rd_word(ga + 32'(8 * i));
        rds++;
        if (hi[30:7] == vsid && hi[6] == 1'(s) && hi[5:0] == ea[27:22]) begin
          rds++;
          pa = {rd_word(ga + 32'(8 * i + 4))[31:12], ea[11:0]};
          flt = 0;
          return;
        end
      end
    end
    pa = '0;
    flt = 1;
  endtask

  task automatic put_pte(logic [23:0] vsid, logic [31:0] ea, bit sec, int slot,
                         logic [19:0] rpn, bit sel);
    logic [31:0] ga;
    ga = grp_addr(vsid, ea, sec) + 32'(8 * slot);
    mem[ga]     = {1'b1, vsid, sel, ea[27:22]};
    mem[ga + 4] = {rpn, 12'h0};
  endtask

  task automatic wr_seg(int idx, logic [31:0] v);
    @(negedge clk);
    cfg_seg_we = 1; cfg_seg_idx = 4'(idx); cfg_wdata = v;
    @(negedge clk);
    cfg_seg_we = 0;
    seg_m[idx] = v;
  endtask

  task automatic wr_tbl(logic [31:0] v);
    @(negedge clk);
    cfg_tbl_we = 1; cfg_wdata = v;
    @(negedge clk);
    cfg_tbl_we = 0;
    tbl_m = v;
  endtask

  task automatic do_req(logic [31:0] ea, bit inst, output logic [31:0] pa,
                        output bit flt, output int rds, output bit was_busy);
    int r0, n;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_ea = ea; req_inst = inst;
    r0 = nreads;
    @(negedge clk);
    req_valid = 0;
    was_busy = !req_ready && !rsp_valid;
    n = 0;
    while (!rsp_valid && n < 1000) begin @(negedge clk); n++; end
    pa = rsp_pa; flt = rsp_fault; rds = nreads - r0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] pa, epa, ea;
    bit flt, eflt, busy;
    int rds, erds;
    for (int i = 0; i < 16; i++) seg_m[i] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 ready", {31'b0, req_ready}, 32'd1);
    check("R1 rsp_valid", {31'b0, rsp_valid}, 32'd0);
    check("R1 mem_valid", {31'b0, mem_valid}, 32'd0);
    rst_n = 1;

    wr_tbl(32'h0010_0000);
    for (int i = 0; i < 16; i++) wr_seg(i, {8'h00, 24'(i * 24'h013579 + 24'h000100)});

    // R2 translation disabled per access type
    for (int m = 0; m < 4; m++) begin
      for (int k = 0; k < 2; k++) begin
        itx_en = m[0]; dtx_en = m[1];
        mem.delete();
        ea = 32'h1234_5678 ^ 32'(m * 32'h1111_0101 + k * 32'h0F0F_0003);
        do_req(ea, bit'(k), pa, flt, rds, busy);
        if (!(k ? m[0] : m[1])) begin
          check("R2 pa", pa, ea);
          check("R2 reads", 32'(rds), 0);
        end else begin
          check("R11 empty fault", {31'b0, flt}, 1);
          check("R11 empty reads", 32'(rds), 16);
          check("R11 empty pa", pa, 0);
        end
      end
    end
    itx_en = 1; dtx_en = 1;

    // R4 direct segment
    wr_seg(5, 32'h8000_000A);
    do_req(32'h5123_4567, 0, pa, flt, rds, busy);
    check("R4 pa", pa, 32'hA123_4567);
    check("R4 reads", 32'(rds), 0);
    wr_seg(5, {8'h00, 24'(5 * 24'h013579 + 24'h000100)});

    // R5 block-translation hit pre-empts walk
    bat_hit = 1; bat_pa = 32'hCAFE_0123;
    do_req(32'h3000_1000, 1, pa, flt, rds, busy);
    check("R5 pa", pa, 32'hCAFE_0123);
    check("R5 reads", 32'(rds), 0);
    bat_hit = 0;

    // R3 R7 R8 R9 R10 sweep: every segment, both groups, every slot
    for (int s = 0; s < 16; s++) begin
      for (int sec = 0; sec < 2; sec++) begin
        for (int slot = 0; slot < 8; slot++) begin
          logic [19:0] rpn;
          ea  = {4'(s), 28'(32'h0135_7000 * (slot + 1) + 32'h0024_6800 * sec + s * 32'h9F)};
          rpn = 20'(32'hA0000 + s * 37 + slot * 5 + sec * 3);
          mem.delete();
          put_pte(seg_m[s][23:0], ea, bit'(sec), slot, rpn, bit'(sec));
          do_req(ea, bit'(slot & 1), pa, flt, rds, busy);
          check("R10 pa", pa, {rpn, ea[11:0]});
          check("R10 fault", {31'b0, flt}, 0);
          check("R8 R11 reads", 32'(rds), 32'(sec * 8 + slot + 2));
          check("R12 busy", {31'b0, busy}, 1);
        end
      end
    end

    // R9 decoys: wrong select bit, wrong api, wrong vsid each skipped
    ea = 32'h7345_6ABC;
    mem.delete();
    put_pte(seg_m[7][23:0], ea, 0, 0, 20'h11111, 1);
    put_pte(seg_m[7][23:0], ea ^ 32'h0040_0000, 0, 1, 20'h22222, 0);
    put_pte(seg_m[7][23:0] ^ 24'h000800, ea, 0, 2, 20'h33333, 0);
    {mem[grp_addr(seg_m[7][23:0], ea, 0) + 24], mem[grp_addr(seg_m[7][23:0], ea, 0) + 28]} =
      {32'h0000_0000 | {1'b0, seg_m[7][23:0], 1'b0, ea[27:22]}, 32'h4444_4000};
    do_req(ea, 0, pa, flt, rds, busy);
    check("R9 bit31 ignored pa", pa, {20'h44444, ea[11:0]});
    check("R9 decoy reads", 32'(rds), 5);
    mem.delete();
    put_pte(seg_m[7][23:0], ea, 0, 3, 20'h55555, 1);
    do_req(ea, 0, pa, flt, rds, busy);
    check("R9 select mismatch fault", {31'b0, flt}, 1);
    check("R11 miss reads", 32'(rds), 16);

    // R6 size field and base change, compared with reference walk
    wr_tbl(32'h0200_01A3);
    for (int k = 0; k < 24; k++) begin
      ea = 32'(k * 32'h1A2B_3C4D + 32'h0F00_0000);
      mem.delete();
      put_pte(seg_m[ea[31:28]][23:0], ea, bit'(k % 2), k % 8, 20'(k * 32'h3171 + 5), bit'(k % 2));
      if (k % 3 == 0) mem.delete();
      ref_walk(ea, epa, eflt, erds);
      do_req(ea, 1, pa, flt, rds, busy);
      check("R6 pa", pa, epa);
      check("R6 fault", {31'b0, flt}, {31'b0, eflt});
      check("R6 reads", 32'(rds), 32'(erds));
    end

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule